// File: doc/BRIEF.md
# Step Timer with Replacement Index

This block keeps a 32-bit step counter, a compare register and a 6-bit replacement index for a 64-entry translation table. It also decides whether an interrupt is requested. Each time the step enable is high, the counter advances by one. When the advanced value reaches the compare value, the block latches a timer-pending flag. In the same step the replacement index moves down by one. When the index reaches the wired floor, it jumps back to the top slot instead, so that slots below the floor are never picked by the rotation.

The pending vector has eight bits. The top bit is the latched timer flag, and the seven lower bits pass the external pending lines straight through. A status write port loads the 8-bit interrupt mask, the global enable and the two level bits that block interrupts, all in one action. The interrupt request is combinational from these stored bits and the pending vector. The caller dispatches the exception. It acknowledges the timer either with the clear input or by rewriting the compare value.

Top module: `step_timer_rnd`

## Requirements
- R1: After reset, the counter reads 0, the index reads 63, the wired floor is 0, the timer-pending bit is 0 and no interrupt is requested.
- R2: On a cycle with step_en high and no counter write, count_o becomes the old value plus one, modulo 2^32. Without a step it holds.
- R3: A counter write loads cnt_wdata on the next cycle and overrides a step in the same cycle. That cycle never sets the timer-pending bit.
- R4: On a step, the index becomes 63 if it equals the wired floor, and otherwise decreases by one. Without a step it holds.
- R5: An index below the wired floor keeps decreasing through 0 and then goes to 63.
- R6: A step whose incremented count equals the compare value sets ip_o[7] on the next cycle. ip_o[6:0] always equal ext_ip, and the timer bit never changes them.
- R7: A compare write or a pulse on tmr_clr clears ip_o[7]. Either one wins over a match in the same cycle.
- R8: The irq_o output is high only when all of these hold: ie = stat bit 0 is 1, the level bit at stat bit 1 is 0, the level bit at stat bit 2 is 0, and ip_o AND mask (stat bits 15:8) is nonzero.
- R9: A status write changes irq_o from the next cycle onward.
- R10: A wired write in the same cycle as a step does not affect that step's index update, which uses the old floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | Advance counter and index this cycle |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 32 | Counter write value |
| cmp_we | input | 1 | Compare write strobe; clears timer pending |
| cmp_wdata | input | 32 | Compare write value |
| wired_we | input | 1 | Wired floor write strobe |
| wired_wdata | input | 6 | Wired floor write value |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Mask in 15:8, ERL-type level bit 2, EXL-type level bit 1, enable bit 0 |
| tmr_clr | input | 1 | Clear timer-pending bit |
| ext_ip | input | 7 | External pending lines |
| count_o | output | 32 | Current counter |
| rand_o | output | 6 | Current replacement index |
| ip_o | output | 8 | Pending vector: timer flag on bit 7 |
| irq_o | output | 1 | Interrupt request |

## Verification
Ordinary stepping does not reach the hardest cases. These are a compare write landing in the very cycle that a step would hit the old compare value, a wired write on a stepping cycle, and an index that sits below the floor and has to wrap through zero. The stimulus reaches them directly. It loads the counter and the compare value through their write ports to sit one step short of a match. It raises the floor to 63 so that the index walks all the way down. A long random phase then mixes all the strobes against a behavioural model that is compared on every clock.

// File: rtl/step_timer_rnd.sv
`timescale 1ns/1ps
module step_timer_rnd #(
  parameter int CNT_W = 32,
  parameter int IDX_W = 6,
  parameter int IP_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             wired_we,
  input  logic [IDX_W-1:0] wired_wdata,
  input  logic             stat_we,
  input  logic [IP_W+7:0]  stat_wdata,
  input  logic             tmr_clr,
  input  logic [IP_W-2:0]  ext_ip,
  output logic [CNT_W-1:0] count_o,
  output logic [IDX_W-1:0] rand_o,
  output logic [IP_W-1:0]  ip_o,
  output logic             irq_o
);

  localparam logic [IDX_W-1:0] RND_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_inc;
  logic [IDX_W-1:0] wired_q, rnd_q;
  logic [IP_W-1:0]  im_q;
  logic             ie_q, exl_q, erl_q, tip_q, hit;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign hit     = step_en & ~cnt_we & (cnt_inc == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (cnt_we)       cnt_q <= cnt_wdata;
      else if (step_en) cnt_q <= cnt_inc;
      if (cmp_we)       cmp_q <= cmp_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnd_q   <= RND_TOP;
      wired_q <= '0;
    end else begin
      if (step_en) rnd_q <= (rnd_q == wired_q) ? RND_TOP : rnd_q - IDX_W'(1);
      if (wired_we) wired_q <= wired_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tip_q <= 1'b0;
    else if (cmp_we | tmr_clr) tip_q <= 1'b0;
    else if (hit)              tip_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      im_q  <= '0;
      ie_q  <= 1'b0;
      exl_q <= 1'b0;
      erl_q <= 1'b0;
    end else if (stat_we) begin
      im_q  <= stat_wdata[IP_W+7:8];
      ie_q  <= stat_wdata[0];
      exl_q <= stat_wdata[1];
      erl_q <= stat_wdata[2];
    end
  end

  assign count_o = cnt_q;
  assign rand_o  = rnd_q;
  assign ip_o    = {tip_q, ext_ip};
  assign irq_o   = ie_q & ~exl_q & ~erl_q & (|(ip_o & im_q));

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !cnt_we) |=> $stable(count_o)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count_o == $past(cnt_wdata))); // R3
  AST_RND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && rand_o == wired_q) |=> (rand_o == RND_TOP)); // R4
  AST_RND_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && rand_o != wired_q) |=> (rand_o == $past(rand_o) - IDX_W'(1))); // R4
  AST_TIP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we || tmr_clr) |=> !ip_o[IP_W-1]); // R7
  AST_LVL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && (stat_wdata[1] || stat_wdata[2] || !stat_wdata[0])) |=> !irq_o); // R8
endmodule

// File: tb/step_timer_rnd_tb.sv
`timescale 1ns/1ps
module step_timer_rnd_tb;
  logic clk = 0, rst_n = 0;
  logic step_en = 0, cnt_we = 0, cmp_we = 0, wired_we = 0, stat_we = 0, tmr_clr = 0;
  logic [31:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [5:0]  wired_wdata = 0;
  logic [15:0] stat_wdata = 0;
  logic [6:0]  ext_ip = 0;
  logic [31:0] count_o;
  logic [5:0]  rand_o;
  logic [7:0]  ip_o;
  logic        irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_cnt, m_cmp;
  logic [5:0]  m_wired, m_rnd;
  logic [7:0]  m_im;
  logic        m_ie, m_exl, m_erl, m_tip;

  always #2 clk = ~clk;

  step_timer_rnd u_dut (.clk(clk), .rst_n(rst_n), .step_en(step_en), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .wired_we(wired_we),
    .wired_wdata(wired_wdata), .stat_we(stat_we), .stat_wdata(stat_wdata), .tmr_clr(tmr_clr),
    .ext_ip(ext_ip), .count_o(count_o), .rand_o(rand_o), .ip_o(ip_o), .irq_o(irq_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_irq();
    return m_ie && !m_exl && !m_erl && (({m_tip, ext_ip} & m_im) != 0);
  endfunction

  task automatic tick();
    logic nhit;
    @(posedge clk);
    nhit = step_en && !cnt_we && (m_cnt + 32'd1 == m_cmp);
    if (cnt_we) m_cnt = cnt_wdata; else if (step_en) m_cnt = m_cnt + 32'd1;
    if (step_en) m_rnd = (m_rnd == m_wired) ? 6'd63 : m_rnd - 6'd1;
    if (wired_we) m_wired = wired_wdata;
    if (cmp_we) m_cmp = cmp_wdata;
    if (cmp_we || tmr_clr) m_tip = 0; else if (nhit) m_tip = 1;
    if (stat_we) begin
      m_im = stat_wdata[15:8]; m_ie = stat_wdata[0];
      m_exl = stat_wdata[1]; m_erl = stat_wdata[2];
    end
    @(negedge clk);
    chk("R2 count", count_o, m_cnt);
    chk("R4 index", {26'd0, rand_o}, {26'd0, m_rnd});
    chk("R6 pending", {24'd0, ip_o}, {24'd0, m_tip, ext_ip});
    chk("R8 irq", {31'd0, irq_o}, {31'd0, m_irq()});
    cnt_we = 0; cmp_we = 0; wired_we = 0; stat_we = 0; tmr_clr = 0;
  endtask

  task automatic wr_stat(logic [15:0] v);
    stat_we = 1; stat_wdata = v; tick();
  endtask

  initial begin
    #600000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_cmp = 0; m_wired = 0; m_rnd = 63; m_im = 0;
    m_ie = 0; m_exl = 0; m_erl = 0; m_tip = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 count", count_o, 0);
    chk("R1 index", {26'd0, rand_o}, 32'd63);
    chk("R1 pending", {24'd0, ip_o}, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    step_en = 1; repeat (10) tick();
    chk("R2 ten steps", count_o, 10);
    chk("R1 floor zero R4", {26'd0, rand_o}, 53);

    step_en = 0; wired_we = 1; wired_wdata = 52; tick();
    chk("R4 hold", {26'd0, rand_o}, 53);
    step_en = 1; tick(); tick();
    chk("R4 floor wrap", {26'd0, rand_o}, 63);
    tick();
    wired_we = 1; wired_wdata = 62; tick();
    chk("R10 old floor used", {26'd0, rand_o}, 61);
    tick();
    chk("R4 after new floor", {26'd0, rand_o}, 60);

    step_en = 0; wired_we = 1; wired_wdata = 63; tick();
    step_en = 1; repeat (60) tick();
    chk("R5 reach zero", {26'd0, rand_o}, 0);
    tick();
    chk("R5 below floor wrap", {26'd0, rand_o}, 63);
    tick();
    chk("R4 at floor", {26'd0, rand_o}, 63);
    wired_we = 1; wired_wdata = 0; tick();

    cnt_we = 1; cnt_wdata = 32'h1000; tick();
    chk("R3 write over step", count_o, 32'h1000);

    step_en = 0; cmp_we = 1; cmp_wdata = 32'h1003; tick();
    wr_stat(16'h8001);
    chk("R9 no pending yet R8", {31'd0, irq_o}, 0);
    step_en = 1; tick(); tick();
    chk("R6 before match", {24'd0, ip_o}, 0);
    tick();
    chk("R6 match sets timer bit", {24'd0, ip_o}, 32'h80);
    chk("R8 irq on timer", {31'd0, irq_o}, 1);
    step_en = 0;
    wr_stat(16'h8003);
    chk("R8 level bit1 blocks", {31'd0, irq_o}, 0);
    wr_stat(16'h8005);
    chk("R8 level bit2 blocks", {31'd0, irq_o}, 0);
    wr_stat(16'h8000);
    chk("R8 enable off", {31'd0, irq_o}, 0);
    wr_stat(16'h8001);
    chk("R9 status restores irq", {31'd0, irq_o}, 1);
    tmr_clr = 1; tick();
    chk("R7 clear input", {24'd0, ip_o}, 0);

    cmp_we = 1; cmp_wdata = m_cnt + 32'd2; tick();
    step_en = 1; tick();
    cmp_we = 1; cmp_wdata = m_cmp; tick();
    chk("R7 clear beats match", {24'd0, ip_o}, 0);

    step_en = 0; cnt_we = 1; cnt_wdata = 32'hFFFF_FFFF; cmp_we = 1; cmp_wdata = 0; tick();
    step_en = 1; tick();
    chk("R2 wrap", count_o, 0);
    chk("R6 match at wrap", {24'd0, ip_o}, 32'h80);

    step_en = 0; tmr_clr = 1; ext_ip = 7'h05; tick();
    wr_stat(16'h0401);
    chk("R8 external overlap", {31'd0, irq_o}, 1);
    ext_ip = 7'h02; tick();
    chk("R6 external mirror", {24'd0, ip_o}, 32'h02);
    chk("R8 no overlap", {31'd0, irq_o}, 0);

    for (int i = 0; i < 4000; i++) begin
      step_en = ($urandom % 10) < 7;
      cnt_we = ($urandom % 50) == 0;   cnt_wdata = $urandom;
      if (($urandom % 4) == 0) cnt_wdata = 32'hFFFF_FFF0 + ($urandom % 16);
      cmp_we = ($urandom % 30) == 0;   cmp_wdata = m_cnt + ($urandom % 6);
      wired_we = ($urandom % 30) == 0; wired_wdata = 6'($urandom);
      stat_we = ($urandom % 20) == 0;  stat_wdata = 16'($urandom);
      tmr_clr = ($urandom % 30) == 0;
      if ((i % 8) == 0) ext_ip = 7'($urandom) & 7'($urandom);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule